// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch Timer

This block handles overcurrent events for one channel of a switching regulator controller, counting in switching cycles. A comparator outside the block reports once per cycle whether the sensed switch current is above its limit. While that flag is high, the block raises a skip signal that stops the high-side switch from turning on in the current cycle. The first trip also starts a timer that runs for sixteen switching cycles. Trips in the first eight of those cycles only cause skipped pulses. A trip in the second eight cycles latches a shutdown request. If no trip arrives in the second half, the timer returns to idle on its own.

The latched request stays set until the enable input is dropped or the block is reset, which stands for the bias supply being cycled. Power-good logic elsewhere uses the latch to hold its output low. When the block serves the follower channel of a tracking pair, a parameter lets a mode input switch the protection off completely.

Top module: `oc_pulse_skip_guard`

## Requirements
- R1: While protection is active (enable high and tracking not in force) and `oc_trip_i` is high, `hs_skip_o` is high in the same clock cycle. While protection is active, not latched and `oc_trip_i` is low, `hs_skip_o` is low.
- R2: The timer sees a trip only on a clock where `cyc_tick_i` and `oc_trip_i` are both high. An overcurrent flag without a tick opens no window. The tick on which an idle block sees a trip is cycle 0 of the window.
- R3: Trips seen at window cycles 1 to 7 (ticks counted after the first trip) never set the latch.
- R4: A trip seen at any window cycle from 8 to 15 sets `shut_req_o` high from the next clock edge.
- R5: If there is no trip at cycles 8 to 15, the block returns to idle at cycle 16. A trip seen exactly at cycle 16 is counted as a fresh cycle 0.
- R6: Once latched, `shut_req_o` and `hs_skip_o` stay high whatever `oc_trip_i` and `cyc_tick_i` do, for as long as enable stays high.
- R7: While `en_i` is low, `hs_skip_o` is low. One clock after `en_i` goes low, `shut_req_o` is low and any open window is discarded.
- R8: With `TRACK_CAPABLE` = 1 and `track_i` high, `hs_skip_o` stays low, no latch forms, and any open window is discarded.
- R9: After `rst_n` is asserted, the block is idle, with `shut_req_o` low and `hs_skip_o` low while `oc_trip_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset (bias supply cycling) |
| en_i | input | 1 | Channel enable; low clears the block |
| track_i | input | 1 | Tracking mode; disables protection when TRACK_CAPABLE = 1 |
| cyc_tick_i | input | 1 | One-clock pulse per switching cycle |
| oc_trip_i | input | 1 | Overcurrent comparator result for the present cycle |
| hs_skip_o | output | 1 | Block the high-side turn-on in this cycle |
| shut_req_o | output | 1 | Latched shutdown request; also forces power-good low |

## Verification
The bound assertions check, on every clock, the rules that relate ports: skip follows an overcurrent flag during active protection, the latch holds, enable and tracking quiet the outputs, and the latch only rises right after a tick that carried a trip. The exact window boundaries can only be shown by the bench scenarios, which place trips at cycles 7, 8, 15 and 16. So can the self-reset at cycle 16 and the discarding of a window by enable or tracking. Each of these is made visible by following it with a trip whose outcome depends on the window position.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

    // Window position of the overcurrent timer
    typedef enum logic [1:0] {
        OCG_IDLE    = 2'd0,   // no trip pending
        OCG_SKIPWIN = 2'd1,   // cycles 0..WIN_LEN-1: skip only
        OCG_ARMWIN  = 2'd2,   // cycles WIN_LEN..2*WIN_LEN-1: trip latches
        OCG_LATCHED = 2'd3    // shutdown requested
    } ocg_state_e;

    typedef struct packed {
        ocg_state_e state;
    } ocg_fsm_s;

endpackage

// File: rtl/oc_tick_counter.sv
module oc_tick_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/oc_window_fsm.sv
module oc_window_fsm
    import oc_guard_pkg::*;
#(
    parameter int WIN_LEN = 8,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             tick_i,
    input  logic             oc_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             clr_o,
    output logic             step_o,
    output logic             latched_o
);

    localparam logic [CNT_W-1:0] ARM_AT = CNT_W'(WIN_LEN);
    localparam logic [CNT_W-1:0] END_AT = CNT_W'(2 * WIN_LEN);

    ocg_fsm_s fsm_d, fsm_q;
    logic [CNT_W-1:0] pos_next;

    always_comb begin
        fsm_d    = fsm_q;
        clr_o    = 1'b0;
        step_o   = 1'b0;
        pos_next = cnt_i + 1'b1;

        if (!active_i) begin
            fsm_d.state = OCG_IDLE;
            clr_o       = 1'b1;
        end else begin
            unique case (fsm_q.state)
                OCG_IDLE: begin
                    if (tick_i && oc_i) begin
                        fsm_d.state = OCG_SKIPWIN;
                        clr_o       = 1'b1;
                    end
                end
                OCG_SKIPWIN, OCG_ARMWIN: begin
                    if (tick_i) begin
                        if (pos_next == END_AT) begin
                            // window expired: new trip starts afresh
                            fsm_d.state = oc_i ? OCG_SKIPWIN : OCG_IDLE;
                            clr_o       = 1'b1;
                        end else if (pos_next >= ARM_AT && oc_i) begin
                            fsm_d.state = OCG_LATCHED;
                        end else begin
                            fsm_d.state = (pos_next >= ARM_AT) ? OCG_ARMWIN
                                                               : OCG_SKIPWIN;
                            step_o      = 1'b1;
                        end
                    end
                end
                OCG_LATCHED: begin
                    fsm_d.state = OCG_LATCHED;
                end
                default: begin
                    fsm_d.state = OCG_IDLE;
                    clr_o       = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= OCG_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign latched_o = (fsm_q.state == OCG_LATCHED);

endmodule

// File: rtl/oc_skip_gate.sv
module oc_skip_gate (
    input  logic active_i,
    input  logic oc_i,
    input  logic latched_i,
    output logic skip_o
);

    always_comb begin
        skip_o = active_i && (oc_i || latched_i);
    end

endmodule

// File: rtl/oc_pulse_skip_guard.sv
module oc_pulse_skip_guard #(
    parameter int WIN_LEN       = 8,
    parameter bit TRACK_CAPABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic track_i,
    input  logic cyc_tick_i,
    input  logic oc_trip_i,
    output logic hs_skip_o,
    output logic shut_req_o
);

    localparam int CNT_W = $clog2(2 * WIN_LEN + 1);

    logic             prot_active;
    logic             cnt_clr, cnt_step, latched;
    logic [CNT_W-1:0] win_cnt;

    generate
        if (TRACK_CAPABLE) begin : g_track
            assign prot_active = en_i && !track_i;
        end else begin : g_plain
            assign prot_active = en_i;
        end
    endgenerate

    oc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .step_i (cnt_step),
        .cnt_o  (win_cnt)
    );

    oc_window_fsm #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (prot_active),
        .tick_i    (cyc_tick_i),
        .oc_i      (oc_trip_i),
        .cnt_i     (win_cnt),
        .clr_o     (cnt_clr),
        .step_o    (cnt_step),
        .latched_o (latched)
    );

    oc_skip_gate u_skip (
        .active_i  (prot_active),
        .oc_i      (oc_trip_i),
        .latched_i (latched),
        .skip_o    (hs_skip_o)
    );

    assign shut_req_o = latched;

endmodule

// File: rtl/oc_pulse_skip_guard_chk.sv
module oc_pulse_skip_guard_chk #(
    parameter bit TRACK_CAPABLE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic track_i,
    input logic cyc_tick_i,
    input logic oc_trip_i,
    input logic hs_skip_o,
    input logic shut_req_o
);

    logic quiet_mode;
    assign quiet_mode = TRACK_CAPABLE && track_i;

    a_r1_skip_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !quiet_mode && oc_trip_i) |-> hs_skip_o);

    a_r2_latch_after_tick_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_req_o) |-> $past(cyc_tick_i && oc_trip_i && en_i));

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_req_o && en_i && !quiet_mode) |=> shut_req_o);

    a_r6_skip_while_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_req_o && en_i && !quiet_mode) |-> hs_skip_o);

    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !shut_req_o);

    a_r7_no_skip_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !hs_skip_o);

    a_r8_track_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_mode |-> !hs_skip_o);

    a_r8_track_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_mode |=> !shut_req_o);

endmodule

bind oc_pulse_skip_guard oc_pulse_skip_guard_chk #(.TRACK_CAPABLE(TRACK_CAPABLE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .track_i    (track_i),
    .cyc_tick_i (cyc_tick_i),
    .oc_trip_i  (oc_trip_i),
    .hs_skip_o  (hs_skip_o),
    .shut_req_o (shut_req_o)
);

// File: tb/oc_pulse_skip_guard_tb_top.sv
module oc_pulse_skip_guard_tb_top;

    logic clk = 1'b0;
    logic rst_n, en, track, tick, oc;
    logic skip, shut;
    int   n_run  = 0;
    int   n_fail = 0;
    logic last_skip;

    always #2 clk = ~clk;   // 250 MHz

    oc_pulse_skip_guard #(.WIN_LEN(8), .TRACK_CAPABLE(1'b1)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .track_i    (track),
        .cyc_tick_i (tick),
        .oc_trip_i  (oc),
        .hs_skip_o  (skip),
        .shut_req_o (shut)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // One switching tick with the given comparator value; skip seen mid-tick
    task automatic do_tick(input logic v);
        @(negedge clk);
        tick = 1'b1;
        oc   = v;
        #1 last_skip = skip;
        @(negedge clk);
        tick = 1'b0;
        oc   = 1'b0;
    endtask

    task automatic quiet_ticks(input int n);
        for (int i = 0; i < n; i++) do_tick(1'b0);
    endtask

    task automatic clear_by_enable();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 shut after reset", shut, 1'b0);
        check("R9 skip after reset", skip, 1'b0);
    endtask

    task automatic t_skip_follows();
        clear_by_enable();
        oc = 1'b1;
        #1 check("R1 skip with trip flag", skip, 1'b1);
        @(negedge clk);
        oc = 1'b0;
        #1 check("R1 skip drops without flag", skip, 1'b0);
        do_tick(1'b1);
        check("R1 skip on tick trip", last_skip, 1'b1);
    endtask

    task automatic t_first_window_only_skips();
        clear_by_enable();
        do_tick(1'b1);                     // cycle 0
        for (int i = 1; i <= 7; i++) do_tick(1'b1);
        check("R3 trips at cycles 1..7 no latch", shut, 1'b0);
        do_tick(1'b1);                     // cycle 8
        check("R4 trip at cycle 8 latches", shut, 1'b1);
    endtask

    task automatic t_latch_holds();
        quiet_ticks(5);
        check("R6 latch holds over quiet ticks", shut, 1'b1);
        check("R6 skip held while latched", last_skip, 1'b1);
        @(negedge clk);
        en = 1'b0;
        #1 check("R7 skip low while disabled", skip, 1'b0);
        @(negedge clk);
        check("R7 latch cleared by enable low", shut, 1'b0);
        en = 1'b1;
        @(negedge clk);
        check("R7 stays clear after enable back", shut, 1'b0);
    endtask

    task automatic t_last_arm_cycle();
        clear_by_enable();
        do_tick(1'b1);                     // cycle 0
        quiet_ticks(14);                   // cycles 1..14
        check("R4 no latch before cycle 15", shut, 1'b0);
        do_tick(1'b1);                     // cycle 15
        check("R4 trip at cycle 15 latches", shut, 1'b1);
    endtask

    task automatic t_self_reset();
        clear_by_enable();
        do_tick(1'b1);                     // cycle 0
        quiet_ticks(16);                   // cycles 1..16: back to idle
        do_tick(1'b1);                     // fresh cycle 0
        do_tick(1'b1);                     // cycle 1
        check("R5 window expired at cycle 16", shut, 1'b0);
        clear_by_enable();
        do_tick(1'b1);                     // cycle 0
        quiet_ticks(15);                   // cycles 1..15
        do_tick(1'b1);                     // cycle 16: fresh trip
        check("R5 trip at cycle 16 no latch", shut, 1'b0);
        quiet_ticks(7);
        do_tick(1'b1);                     // cycle 8 of new window
        check("R5 cycle-16 trip opened new window", shut, 1'b1);
    endtask

    task automatic t_tick_needed();
        clear_by_enable();
        @(negedge clk);
        oc = 1'b1;
        repeat (10) @(negedge clk);
        check("R2 skip from untimed flag", skip, 1'b1);
        oc = 1'b0;
        quiet_ticks(8);
        do_tick(1'b1);                     // must be a fresh cycle 0
        do_tick(1'b1);                     // cycle 1
        check("R2 flag without tick opens no window", shut, 1'b0);
    endtask

    task automatic t_enable_drops_window();
        clear_by_enable();
        do_tick(1'b1);                     // cycle 0
        quiet_ticks(8);                    // in second window now
        clear_by_enable();
        do_tick(1'b1);                     // fresh cycle 0
        check("R7 enable low discarded window", shut, 1'b0);
        @(negedge clk);
        en = 1'b0;
        do_tick(1'b1);
        check("R7 no skip on trip while disabled", last_skip, 1'b0);
        en = 1'b1;
    endtask

    task automatic t_tracking();
        clear_by_enable();
        do_tick(1'b1);                     // cycle 0 before tracking
        quiet_ticks(8);
        @(negedge clk);
        track = 1'b1;
        for (int i = 0; i < 20; i++) begin
            do_tick(1'b1);
            if (i == 0) check("R8 no skip in tracking", last_skip, 1'b0);
        end
        check("R8 no latch in tracking", shut, 1'b0);
        @(negedge clk);
        track = 1'b0;
        do_tick(1'b1);                     // fresh cycle 0
        do_tick(1'b1);                     // cycle 1
        check("R8 tracking discarded window", shut, 1'b0);
    endtask

    task automatic t_reset_clears_latch();
        clear_by_enable();
        do_tick(1'b1);
        quiet_ticks(9);
        do_tick(1'b1);                     // cycle 10
        check("R4 trip at cycle 10 latches", shut, 1'b1);
        t_reset();
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; track = 1'b0; tick = 1'b0; oc = 1'b0;
        last_skip = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        en    = 1'b1;
        @(negedge clk);
        check("R9 shut at start", shut, 1'b0);
        check("R9 skip at start", skip, 1'b0);
        t_skip_follows();
        t_first_window_only_skips();
        t_latch_holds();
        t_last_arm_cycle();
        t_self_reset();
        t_tick_needed();
        t_enable_drops_window();
        t_tracking();
        t_reset_clears_latch();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule